// File: doc/BRIEF.md
# Bidirectional I/O Port with Upper-Nibble Change Interrupt

This block is an eight-bit general-purpose I/O port for a small microcontroller. Every bit has its own direction control. A direction bit of one makes the pin an input, and a zero drives the output latch onto the pin. One shared control bit, active low, turns on weak pull-ups for all pins together. A pin's pull-up is forced off while that pin is an output. Software reaches the port through single-cycle strobes that write the port, write the direction, write the option bit, read the port and read the direction, all over an eight-bit data bus.

The upper four pins can raise a change interrupt. Each pin there that is configured as an input is compared against a snapshot of its level. The snapshot is taken on every port read or port write. Any difference sets a sticky change flag, and that flag also drives a wake request. While the difference stays, the flag is set again every cycle. Software therefore reads or writes the port first to end the mismatch, then pulses the flag clear.

Top module: `gpio_chg_port`

## Requirements
- R1: After reset the direction register is all ones (every pin an input), the output latch is zero, pull-ups are off and the change flag is zero.
- R2: A `wr_dir` pulse loads the direction register from `bus_wdata`, and `rd_dir` returns it on `rd_data`. `pin_oe` is the bitwise inverse of the direction register and `pin_out` is the output latch.
- R3: While `rd_port` is high, `rd_data` returns the synchronized pin level for input bits and the latch value for output bits. A pin change becomes visible after two rising clock edges.
- R4: A `wr_opt` pulse with `bus_wdata[7]`=0 enables pull-ups and with `bus_wdata[7]`=1 disables them. `pin_pu` for a bit is high only when pull-ups are enabled and that bit is an input.
- R5: When any upper input pin (bits 7..4, direction 1) differs from its snapshot, the flag is set on the next edge. Upper pins that are outputs, and bits 3..0, never set the flag.
- R6: A port read or a port write loads the snapshot from the current synchronized levels of bits 7..4, which ends the mismatch.
- R7: While a mismatch persists, a `clr_flag` pulse leaves the flag set, because setting wins over clearing in the same cycle. Without a mismatch, `clr_flag` clears the flag on the next edge.
- R8: `wake_req` is high exactly when the change flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wdata | input | 8 | Write data bus |
| wr_port | input | 1 | Write output latch (also reloads snapshot) |
| wr_dir | input | 1 | Write direction register |
| wr_opt | input | 1 | Write pull-up control from bit 7 (0 = enable) |
| rd_port | input | 1 | Read port levels (also reloads snapshot) |
| rd_dir | input | 1 | Read direction register |
| clr_flag | input | 1 | Clear change flag |
| rd_data | output | 8 | Read data |
| pin_in | input | 8 | Raw asynchronous pin levels |
| pin_oe | output | 8 | Per-pin output driver enable |
| pin_out | output | 8 | Per-pin output value |
| pin_pu | output | 8 | Per-pin weak pull-up enable |
| chg_flag | output | 1 | Change interrupt flag |
| wake_req | output | 1 | Wake-from-sleep request |

## Verification
A flag clear and a fresh mismatch can land on the same rising edge. The bench provokes this by changing an upper input pin and then pulsing `clr_flag` in exactly the cycle where the synchronized level first differs from the snapshot. It then expects the flag to be high. The reverse order is also checked: a port read ends the mismatch and the clear that follows succeeds. This shows that clearing depends on the snapshot having been refreshed.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   // bit of the option write that carries the active-low pull-up control
   localparam int PU_CTRL_BIT = 7;
   // reset state of the pull-up disable bit (1 = pull-ups off)
   localparam logic PU_DIS_RST = 1'b1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("gpio_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stg[s] <= '0;
            else if (s == 0) stg[s] <= d;
            else             stg[s] <= stg[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] lvl,
   input  logic [CW-1:0] in_mask,
   input  logic          capture,
   input  logic          clr,
   output logic          flag
);
   logic [CW-1:0] snap;
   logic          mismatch;

   assign mismatch = |((lvl ^ snap) & in_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       snap <= '0;
      else if (capture) snap <= lvl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag <= 1'b0;
      else if (mismatch) flag <= 1'b1;
      else if (clr)      flag <= 1'b0;
   end

   // R5 / R7: a live mismatch always leaves the flag set
   a_r5_mismatch_sets: assert property (@(posedge clk) disable iff (!rst_n)
      mismatch |=> flag);
   // R7: clear without mismatch drops the flag
   a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !mismatch) |=> !flag);
   // R6: snapshot follows the levels seen at the capture
   a_r6_snap_load: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> snap == $past(lvl));
   // R7: without a mismatch the flag never rises
   a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!mismatch && !flag) |=> !flag);
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port #(
   parameter int PORT_W      = 8,
   parameter int CHG_LO      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] bus_wdata,
   input  logic              wr_port,
   input  logic              wr_dir,
   input  logic              wr_opt,
   input  logic              rd_port,
   input  logic              rd_dir,
   input  logic              clr_flag,
   output logic [PORT_W-1:0] rd_data,
   input  logic [PORT_W-1:0] pin_in,
   output logic [PORT_W-1:0] pin_oe,
   output logic [PORT_W-1:0] pin_out,
   output logic [PORT_W-1:0] pin_pu,
   output logic              chg_flag,
   output logic              wake_req
);
   import gpio_pkg::*;

   localparam int CW = PORT_W - CHG_LO;

   generate
      if (CHG_LO < 0 || CHG_LO >= PORT_W) begin : g_bad_lo
         $error("gpio_chg_port: CHG_LO out of range");
      end
      if (PORT_W <= PU_CTRL_BIT) begin : g_bad_w
         $error("gpio_chg_port: PORT_W too narrow for pull-up control bit");
      end
   endgenerate

   logic [PORT_W-1:0] dir_q, lat_q, lvl;
   logic              pu_dis_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q    <= '1;
         lat_q    <= '0;
         pu_dis_q <= PU_DIS_RST;
      end else begin
         if (wr_dir)  dir_q    <= bus_wdata;
         if (wr_port) lat_q    <= bus_wdata;
         if (wr_opt)  pu_dis_q <= bus_wdata[PU_CTRL_BIT];
      end
   end

   gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
   );

   gpio_chg_detect #(.CW(CW)) u_det (
      .clk(clk), .rst_n(rst_n),
      .lvl(lvl[PORT_W-1:CHG_LO]),
      .in_mask(dir_q[PORT_W-1:CHG_LO]),
      .capture(rd_port | wr_port),
      .clr(clr_flag),
      .flag(chg_flag)
   );

   assign pin_oe   = ~dir_q;
   assign pin_out  = lat_q;
   assign pin_pu   = dir_q & {PORT_W{~pu_dis_q}};
   assign wake_req = chg_flag;

   always_comb begin
      if (rd_port)     rd_data = (dir_q & lvl) | (~dir_q & lat_q);
      else if (rd_dir) rd_data = dir_q;
      else             rd_data = '0;
   end

   // R2: a direction write is reflected on the enables one edge later
   a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dir |=> pin_oe == ~$past(bus_wdata));
   // R4: disabling pull-ups removes every pull-up
   a_r4_pu_off: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_opt && bus_wdata[PU_CTRL_BIT]) |=> pin_pu == '0);
   // R4: a driven pin never also pulls up
   a_r4_pu_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & pin_pu) == '0);
   // R2: port write lands in the output latch
   a_r2_latch_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_port |=> pin_out == $past(bus_wdata));
endmodule

// File: tb/gpio_chg_port_test.sv
module gpio_chg_port_test;
   logic       clk = 0, rst_n = 0;
   logic [7:0] bus_wdata = 0, pin_in = 0;
   logic       wr_port = 0, wr_dir = 0, wr_opt = 0, rd_port = 0, rd_dir = 0, clr_flag = 0;
   logic [7:0] rd_data, pin_oe, pin_out, pin_pu;
   logic       chg_flag, wake_req;
   int         n_run = 0, n_fail = 0;

   always #5 clk = ~clk;

   gpio_chg_port uut (
      .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .wr_port(wr_port),
      .wr_dir(wr_dir), .wr_opt(wr_opt), .rd_port(rd_port), .rd_dir(rd_dir),
      .clr_flag(clr_flag), .rd_data(rd_data), .pin_in(pin_in), .pin_oe(pin_oe),
      .pin_out(pin_out), .pin_pu(pin_pu), .chg_flag(chg_flag), .wake_req(wake_req)
   );

   // {dir, latch, pins, expected port read}
   localparam logic [31:0] VEC [5] = '{
      32'hFF_00_A5_A5, 32'h00_3C_FF_3C, 32'hF0_5A_0F_0A,
      32'h0F_C3_96_C6, 32'hCF_30_55_75 };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_wr(input int kind, input logic [7:0] d);
      @(negedge clk);
      bus_wdata = d;
      wr_port = (kind == 0); wr_dir = (kind == 1); wr_opt = (kind == 2);
      @(negedge clk);
      wr_port = 0; wr_dir = 0; wr_opt = 0;
   endtask

   task automatic read(input logic port, output logic [7:0] v);
      @(negedge clk);
      rd_port = port; rd_dir = !port;
      #1 v = rd_data;
      @(negedge clk);
      rd_port = 0; rd_dir = 0;
   endtask

   task automatic clear;
      @(negedge clk); clr_flag = 1;
      @(negedge clk); clr_flag = 0;
   endtask

   initial begin
      #1ms;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] v;
      tick(2); rst_n = 1; tick(1);
      // R1 reset state
      read(0, v);        chk("R1 dir", v, 8'hFF);
      chk("R1 oe", pin_oe, 8'h00);
      chk("R1 latch", pin_out, 8'h00);
      chk("R1 pu", pin_pu, 8'h00);
      chk("R1 flag", {7'b0, chg_flag}, 8'h00);

      // table walk: R2 / R3
      foreach (VEC[i]) begin
         pulse_wr(1, VEC[i][31:24]);
         pulse_wr(0, VEC[i][23:16]);
         pin_in = VEC[i][15:8];
         tick(3);
         chk("R2 oe", pin_oe, ~VEC[i][31:24]);
         chk("R2 out", pin_out, VEC[i][23:16]);
         read(0, v); chk("R2 dir readback", v, VEC[i][31:24]);
         read(1, v); chk("R3 port read", v, VEC[i][7:0]);
      end

      // R4 pull-up gating
      pulse_wr(1, 8'hF0);
      pulse_wr(2, 8'h7F);  chk("R4 pu on", pin_pu, 8'hF0);
      pulse_wr(2, 8'h80);  chk("R4 pu off", pin_pu, 8'h00);

      // R3 synchronizer latency
      pulse_wr(1, 8'hFF);
      pin_in = 8'h00; tick(3);
      read(1, v); clear; tick(1);
      chk("R7 idle clear", {7'b0, chg_flag}, 8'h00);
      @(negedge clk); pin_in = 8'h01;
      @(negedge clk); rd_port = 1; #1 v = rd_data;
      chk("R3 one edge", v, 8'h00);
      @(negedge clk); #1 v = rd_data;
      chk("R3 two edges", v, 8'h01);
      rd_port = 0; tick(4);
      // R5 lower nibble ignored
      pin_in = 8'h03; tick(4);
      chk("R5 low bits", {7'b0, chg_flag}, 8'h00);

      // R5 / R8 upper change sets flag and wake
      pin_in = 8'h23; tick(3);
      chk("R5 set", {7'b0, chg_flag}, 8'h01);
      chk("R8 wake", {7'b0, wake_req}, 8'h01);
      clear; tick(1);
      chk("R7 persist", {7'b0, chg_flag}, 8'h01);
      read(1, v); clear; tick(1);
      chk("R6 R7 read then clear", {7'b0, chg_flag}, 8'h00);
      chk("R8 wake low", {7'b0, wake_req}, 8'h00);

      // R5 output-configured upper pin excluded
      pulse_wr(1, 8'h7F);
      pin_in = 8'hA3; tick(4);
      chk("R5 output excluded", {7'b0, chg_flag}, 8'h00);
      pulse_wr(1, 8'hFF); tick(1);
      chk("R5 input again", {7'b0, chg_flag}, 8'h01);
      // R6 port write ends mismatch
      pulse_wr(0, 8'h00); clear; tick(1);
      chk("R6 write then clear", {7'b0, chg_flag}, 8'h00);

      // R7 set wins over clear in the same edge
      @(negedge clk); pin_in = 8'hB3;
      @(negedge clk);
      @(negedge clk); clr_flag = 1;
      @(negedge clk); clr_flag = 0;
      chk("R7 set wins", {7'b0, chg_flag}, 8'h01);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule